// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Slice

This block multiplies two operands every enabled clock and folds the product into a running total. The product can be added to the total or taken away from it, and the choice can change from one cycle to the next. The operands can be read as unsigned numbers or as two's complement numbers, and that choice can also change every cycle. The total sits in an output register that is always present. A registered flag reports that the total has left its representable range.

Each operand passes through its own input register. That register takes either the external operand or the value offered by a neighbouring slice, and its content is driven out again so that slices can be chained into a shift line. The input registers and the register between multiplier and accumulator are optional and are chosen by parameter. The per-cycle controls travel through the same optional stages as the operands, so every control meets the product it was issued with. A load input replaces the total with the current product or with zero, and a synchronous reset clears everything.

Top module: `mac_slice`

## Requirements
- R1: With both optional stages present (the default), operands and controls applied on an enabled cycle change `acc` at the third enabled rising edge after they are applied. Each enabled cycle changes the total by exactly one product.
- R2: While `ce` is 0, no register changes: `acc`, `ovf`, `a_shout` and `b_shout` hold, and operands already inside the pipeline are kept rather than lost.
- R3: `sgn`=1 reads both operands and the total as two's complement and `sgn`=0 reads them as unsigned. The choice is taken per cycle and governs the product it was issued with.
- R4: `sub`=0 adds the product to the total and `sub`=1 subtracts it. The choice is taken per cycle and aligned with its product.
- R5: `a_sel`/`b_sel` pick the operand register source: 0 loads `a_in`/`b_in`, 1 loads `a_shin`/`b_shin`. `a_shout`/`b_shout` show the operand register content, one enabled edge after the load.
- R6: `acc_ld`=1 replaces the total instead of accumulating: with `ld_zero`=0 it becomes the product issued with it (extended per `sgn`), with `ld_zero`=1 it becomes 0. A load also clears `ovf`.
- R7: `ovf` becomes 1 at the edge where the exact sum or difference falls outside 0 to 2^ACC_W-1 (`sgn`=0) or -2^(ACC_W-1) to 2^(ACC_W-1)-1 (`sgn`=1). It stays 1 until a load or a reset.
- R8: `rst`=1 at a rising edge clears the total, `ovf`, the shift outputs and every pipeline stage, whatever the value of `ce`.
- R9: The operand width OP_W is 9, 18 or 36. The product is 2*OP_W bits and `acc` is 2*OP_W+GUARD_W bits wide, so a full-scale unsigned product loads with zeros in the guard bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every register |
| a_in | input | OP_W | Parallel operand A |
| b_in | input | OP_W | Parallel operand B |
| a_sel | input | 1 | Source of operand A register: 0 parallel, 1 shift-in |
| b_sel | input | 1 | Source of operand B register: 0 parallel, 1 shift-in |
| a_shin | input | OP_W | Operand A from the previous slice |
| b_shin | input | OP_W | Operand B from the previous slice |
| a_shout | output | OP_W | Operand A register content, to the next slice |
| b_shout | output | OP_W | Operand B register content, to the next slice |
| sgn | input | 1 | 1 two's complement, 0 unsigned |
| sub | input | 1 | 1 subtract product, 0 add product |
| acc_ld | input | 1 | Replace the total instead of accumulating |
| ld_zero | input | 1 | With acc_ld: 1 loads zero, 0 loads the product |
| acc | output | 2*OP_W+GUARD_W | Accumulated total |
| ovf | output | 1 | Sticky range overflow flag |

## Verification
Small directed operands, one set per pattern, show the three-edge latency and keep add apart from subtract and signed apart from unsigned. An operand of all ones is large in one reading and -1 in the other. Shift-in sources that differ from the parallel operands show which path was taken. Clock-enable gaps placed in the middle of a burst show whether the pipeline holds its contents or drops them. An unsigned subtraction from zero, a signed result that turns negative, and a long unsigned run of full-scale products show when the range flag must be raised and when it must not. A long random mix of operands, modes, enables and loads is then compared cycle by cycle with a model kept in the bench.

// File: rtl/mac_pkg.sv
package mac_pkg;

   // Controls that travel with an operand pair through the pipeline
   typedef struct packed {
      logic sgn;      // 1: two's complement
      logic sub;      // 1: subtract product
      logic ld;       // replace total
      logic lz;       // replace with zero
   } mac_ctl_t;

   localparam int CTL_W = $bits(mac_ctl_t);

endpackage

// File: rtl/mac_stage.sv
// Optional register stage: EN=1 registers, EN=0 passes through.
module mac_stage #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (EN) begin : g_reg
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)     r <= '0;
            else if (ce) r <= d;
         end
         assign q = r;
      end else begin : g_wire
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/mac_opreg.sv
// Operand register with parallel / shift-in source select.
module mac_opreg #(
   parameter int W  = 18,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic         sel,
   input  logic [W-1:0] par_d,
   input  logic [W-1:0] sh_d,
   output logic [W-1:0] q
);
   logic [W-1:0] pick;

   assign pick = sel ? sh_d : par_d;

   mac_stage #(.W(W), .EN(EN)) u_stage (
      .clk (clk),
      .rst (rst),
      .ce  (ce),
      .d   (pick),
      .q   (q)
   );
endmodule

// File: rtl/mac_mult.sv
// Signed or unsigned multiplier; low 2*W bits of the exact product.
module mac_mult #(
   parameter int W = 18
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           sgn,
   output logic [2*W-1:0] p
);
   logic [2*W-1:0] ax;
   logic [2*W-1:0] bx;

   // Extending to the product width makes modular multiply exact
   assign ax = {{W{sgn & a[W-1]}}, a};
   assign bx = {{W{sgn & b[W-1]}}, b};
   assign p  = ax * bx;
endmodule

// File: rtl/mac_accum.sv
// Accumulator register with add/sub, load and sticky overflow.
module mac_accum
   import mac_pkg::*;
#(
   parameter int PROD_W = 36,
   parameter int ACC_W  = 52
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic [PROD_W-1:0] prod,
   input  mac_ctl_t          ctl,
   output logic [ACC_W-1:0]  acc,
   output logic              ovf
);
   localparam int XW = ACC_W + 2;

   logic [ACC_W-1:0] acc_q;
   logic             ovf_q;
   logic [XW-1:0]    px;
   logic [XW-1:0]    ax;
   logic [XW-1:0]    sx;
   logic [2:0]       top_s;
   logic             out_s;
   logic             out_u;

   assign px = {{(XW-PROD_W){ctl.sgn & prod[PROD_W-1]}}, prod};
   assign ax = {{2{ctl.sgn & acc_q[ACC_W-1]}}, acc_q};
   assign sx = ctl.sub ? (ax - px) : (ax + px);

   assign top_s = sx[XW-1:ACC_W-1];
   assign out_s = !((top_s == 3'b000) || (top_s == 3'b111));
   assign out_u = (sx[XW-1:ACC_W] != 2'b00);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (ce) begin
         if (ctl.ld) begin
            acc_q <= ctl.lz ? '0 : px[ACC_W-1:0];
            ovf_q <= 1'b0;
         end else begin
            acc_q <= sx[ACC_W-1:0];
            ovf_q <= ovf_q | (ctl.sgn ? out_s : out_u);
         end
      end
   end

   assign acc = acc_q;
   assign ovf = ovf_q;
endmodule

// File: rtl/mac_slice.sv
module mac_slice
   import mac_pkg::*;
#(
   parameter int OP_W     = 18,
   parameter int GUARD_W  = 16,
   parameter bit IN_REG   = 1'b1,
   parameter bit PIPE_REG = 1'b1,
   localparam int PROD_W  = 2 * OP_W,
   localparam int ACC_W   = PROD_W + GUARD_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic [OP_W-1:0]  a_in,
   input  logic [OP_W-1:0]  b_in,
   input  logic             a_sel,
   input  logic             b_sel,
   input  logic [OP_W-1:0]  a_shin,
   input  logic [OP_W-1:0]  b_shin,
   output logic [OP_W-1:0]  a_shout,
   output logic [OP_W-1:0]  b_shout,
   input  logic             sgn,
   input  logic             sub,
   input  logic             acc_ld,
   input  logic             ld_zero,
   output logic [ACC_W-1:0] acc,
   output logic             ovf
);
   localparam int PIPE_W = PROD_W + CTL_W;

   generate
      if (!(OP_W == 9 || OP_W == 18 || OP_W == 36)) begin : g_bad_opw
         $error("mac_slice: OP_W must be 9, 18 or 36");
      end
      if (GUARD_W < 1) begin : g_bad_guard
         $error("mac_slice: GUARD_W must be at least 1");
      end
   endgenerate

   mac_ctl_t          ctl_in;
   mac_ctl_t          ctl_s1;
   mac_ctl_t          ctl_p;
   logic [CTL_W-1:0]  ctl_s1_v;
   logic [OP_W-1:0]   a_q;
   logic [OP_W-1:0]   b_q;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] prod_p;
   logic [PIPE_W-1:0] pipe_d;
   logic [PIPE_W-1:0] pipe_q;
   logic              ld_p;

   assign ctl_in = '{sgn: sgn, sub: sub, ld: acc_ld, lz: ld_zero};

   // Input stage: operands with source select, controls alongside
   mac_opreg #(.W(OP_W), .EN(IN_REG)) u_areg (
      .clk (clk), .rst (rst), .ce (ce), .sel (a_sel),
      .par_d (a_in), .sh_d (a_shin), .q (a_q)
   );

   mac_opreg #(.W(OP_W), .EN(IN_REG)) u_breg (
      .clk (clk), .rst (rst), .ce (ce), .sel (b_sel),
      .par_d (b_in), .sh_d (b_shin), .q (b_q)
   );

   mac_stage #(.W(CTL_W), .EN(IN_REG)) u_ctl1 (
      .clk (clk), .rst (rst), .ce (ce),
      .d (ctl_in), .q (ctl_s1_v)
   );
   assign ctl_s1 = mac_ctl_t'(ctl_s1_v);

   assign a_shout = a_q;
   assign b_shout = b_q;

   mac_mult #(.W(OP_W)) u_mult (
      .a (a_q), .b (b_q), .sgn (ctl_s1.sgn), .p (prod)
   );

   // Pipeline stage between multiplier and accumulator
   assign pipe_d = {prod, ctl_s1};

   mac_stage #(.W(PIPE_W), .EN(PIPE_REG)) u_pipe (
      .clk (clk), .rst (rst), .ce (ce),
      .d (pipe_d), .q (pipe_q)
   );

   assign prod_p = pipe_q[PIPE_W-1:CTL_W];
   assign ctl_p  = mac_ctl_t'(pipe_q[CTL_W-1:0]);
   assign ld_p   = ctl_p.ld;

   mac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
      .clk (clk), .rst (rst), .ce (ce),
      .prod (prod_p), .ctl (ctl_p),
      .acc (acc), .ovf (ovf)
   );
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
   parameter int OP_W   = 18,
   parameter int ACC_W  = 52,
   parameter bit IN_REG = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             ce,
   input logic             a_sel,
   input logic             b_sel,
   input logic [OP_W-1:0]  a_shin,
   input logic [OP_W-1:0]  b_shin,
   input logic [OP_W-1:0]  a_shout,
   input logic [OP_W-1:0]  b_shout,
   input logic [ACC_W-1:0] acc,
   input logic             ovf,
   input logic             ld_p
);
   // R2: a disabled cycle leaves the total and flag untouched
   a_r2_hold_total: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(acc) && $stable(ovf)));

   // R6: a load reaching the accumulator clears the flag
   a_r6_load_clears: assert property (@(posedge clk) disable iff (rst)
      (ce && ld_p) |=> !ovf);

   // R7: flag is sticky until a load
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      (ovf && !(ce && ld_p)) |=> ovf);

   // R8: reset clears the visible state
   a_r8_reset_clear: assert property (@(posedge clk)
      rst |=> (acc == '0 && !ovf && a_shout == '0 && b_shout == '0));

   generate
      if (IN_REG) begin : g_shift_chk
         // R5: shift-in selected -> register shows the neighbour's value
         a_r5_shift_a: assert property (@(posedge clk) disable iff (rst)
            (ce && a_sel) |=> (a_shout == $past(a_shin)));
         a_r5_shift_b: assert property (@(posedge clk) disable iff (rst)
            (ce && b_sel) |=> (b_shout == $past(b_shin)));
      end
   endgenerate
endmodule

bind mac_slice mac_slice_chk #(
   .OP_W   (OP_W),
   .ACC_W  (ACC_W),
   .IN_REG (IN_REG)
) u_mac_slice_chk (
   .clk     (clk),
   .rst     (rst),
   .ce      (ce),
   .a_sel   (a_sel),
   .b_sel   (b_sel),
   .a_shin  (a_shin),
   .b_shin  (b_shin),
   .a_shout (a_shout),
   .b_shout (b_shout),
   .acc     (acc),
   .ovf     (ovf),
   .ld_p    (ld_p)
);

// File: tb/test_mac_slice.sv
module test_mac_slice;
   localparam int OPW  = 18;
   localparam int ACCW = 52;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            ce = 1'b0;
   logic [OPW-1:0]  a_in = '0, b_in = '0, a_shin = '0, b_shin = '0;
   logic            a_sel = 1'b0, b_sel = 1'b0;
   logic            sgn = 1'b0, sub = 1'b0, acc_ld = 1'b0, ld_zero = 1'b0;
   logic [OPW-1:0]  a_shout, b_shout;
   logic [ACCW-1:0] acc;
   logic            ovf;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   mac_slice i_mac_slice (
      .clk (clk), .rst (rst), .ce (ce),
      .a_in (a_in), .b_in (b_in), .a_sel (a_sel), .b_sel (b_sel),
      .a_shin (a_shin), .b_shin (b_shin),
      .a_shout (a_shout), .b_shout (b_shout),
      .sgn (sgn), .sub (sub), .acc_ld (acc_ld), .ld_zero (ld_zero),
      .acc (acc), .ovf (ovf)
   );

   always #2 clk = ~clk;   // 250 MHz

   // Bench model state
   logic [OPW-1:0]  s1_a, s1_b;
   logic            s1_sgn, s1_sub, s1_ld, s1_lz;
   longint          s2_p;
   logic            s2_sgn, s2_sub, s2_ld, s2_lz;
   logic [ACCW-1:0] m_acc;
   logic            m_ovf;

   function automatic longint mul_ref(logic [OPW-1:0] x, logic [OPW-1:0] y, logic s);
      if (s) return longint'($signed(x)) * longint'($signed(y));
      return longint'(x) * longint'(y);
   endfunction

   function automatic bit out_of_range(longint r, logic s);
      if (s) return (r < -(longint'(1) <<< (ACCW-1))) || (r >= (longint'(1) <<< (ACCW-1)));
      return (r < 0) || (r >= (longint'(1) <<< ACCW));
   endfunction

   task automatic model_edge();
      longint accv, res;
      if (rst) begin
         s1_a = '0; s1_b = '0; {s1_sgn, s1_sub, s1_ld, s1_lz} = '0;
         s2_p = 0; {s2_sgn, s2_sub, s2_ld, s2_lz} = '0;
         m_acc = '0; m_ovf = 1'b0;
      end else if (ce) begin
         if (s2_ld) begin
            m_acc = s2_lz ? '0 : s2_p[ACCW-1:0];
            m_ovf = 1'b0;
         end else begin
            accv = s2_sgn ? longint'($signed(m_acc)) : longint'({12'b0, m_acc});
            res  = s2_sub ? accv - s2_p : accv + s2_p;
            if (out_of_range(res, s2_sgn)) m_ovf = 1'b1;
            m_acc = res[ACCW-1:0];
         end
         s2_p = mul_ref(s1_a, s1_b, s1_sgn);
         {s2_sgn, s2_sub, s2_ld, s2_lz} = {s1_sgn, s1_sub, s1_ld, s1_lz};
         s1_a = a_sel ? a_shin : a_in;
         s1_b = b_sel ? b_shin : b_in;
         {s1_sgn, s1_sub, s1_ld, s1_lz} = {sgn, sub, acc_ld, ld_zero};
      end
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model_edge();
      #1;
      checks++;
      if (acc !== m_acc || ovf !== m_ovf || a_shout !== s1_a || b_shout !== s1_b) begin
         fails++;
         $display("FAIL %s: acc=%h ovf=%b ash=%h bsh=%h expected acc=%h ovf=%b ash=%h bsh=%h",
                  tag, acc, ovf, a_shout, b_shout, m_acc, m_ovf, s1_a, s1_b);
      end
   endtask

   task automatic drive(logic [OPW-1:0] a, logic [OPW-1:0] b, logic s, logic sb,
                        logic ld, logic lz, logic e);
      a_in = a; b_in = b; sgn = s; sub = sb; acc_ld = ld; ld_zero = lz; ce = e;
      a_sel = 1'b0; b_sel = 1'b0;
   endtask

   task automatic expect_val(string tag, logic [ACCW-1:0] ea, logic eo);
      checks++;
      if (acc !== ea || ovf !== eo) begin
         fails++;
         $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", tag, acc, ovf, ea, eo);
      end
   endtask

   task automatic flush(string tag);
      drive('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      repeat (3) tick(tag);
   endtask

   task automatic clear();
      rst = 1'b1; tick("R8"); rst = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !done) begin
         fails++; checks++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      model_edge();
      tick("R8"); tick("R8");
      // R8: reset state
      expect_val("R8", '0, 1'b0);
      rst = 1'b0;

      // R1: unsigned 3*5 appears on the third edge
      drive(18'd3, 18'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      tick("R1");
      drive('0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      tick("R1");
      expect_val("R1", '0, 1'b0);
      tick("R1");
      expect_val("R1", 52'd15, 1'b0);

      // R4: subtract 2*4 -> 7
      drive(18'd2, 18'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      tick("R4");
      flush("R4");
      expect_val("R4", 52'd7, 1'b0);

      // R3: all-ones * 2, signed -> -2 added gives 5
      drive('1, 18'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      tick("R3");
      // R3: same operands unsigned on the next cycle
      drive('1, 18'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      tick("R3");
      flush("R3");
      expect_val("R3", 52'd5 + 52'h7FFFE, 1'b0);

      // R5: shift-in source
      clear();
      drive(18'd9, 18'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      a_sel = 1'b1; b_sel = 1'b1; a_shin = 18'd6; b_shin = 18'd7;
      tick("R5");
      flush("R5");
      expect_val("R5", 52'd42, 1'b0);

      // R2: enable gap holds everything in flight
      drive(18'd10, 18'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      tick("R2");
      drive(18'd1000, 18'd1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      repeat (4) tick("R2");
      expect_val("R2", 52'd42, 1'b0);
      flush("R2");
      expect_val("R2", 52'd142, 1'b0);

      // R6: load product, then load zero
      drive(18'd11, 18'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      tick("R6");
      flush("R6");
      expect_val("R6", 52'd33, 1'b0);
      drive(18'd11, 18'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      tick("R6");
      flush("R6");
      expect_val("R6", 52'd0, 1'b0);

      // R7: unsigned subtract below zero flags and sticks
      drive(18'd1, 18'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      tick("R7");
      flush("R7");
      expect_val("R7", '1, 1'b1);
      flush("R7");
      expect_val("R7", '1, 1'b1);
      // R6: load clears the flag
      drive(18'd0, 18'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      tick("R6");
      flush("R6");
      expect_val("R6", '0, 1'b0);

      // R7: signed result going negative is in range
      drive(18'd1, 18'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      tick("R7");
      flush("R7");
      expect_val("R7", '1, 1'b0);

      // R9: full-scale unsigned product loads with clear guard bits
      drive('1, '1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      tick("R9");
      flush("R9");
      expect_val("R9", 52'h0000F_FFF8_0001, 1'b0);

      // R8: reset with ce low still clears
      ce = 1'b0; rst = 1'b1; tick("R8"); rst = 1'b0;
      expect_val("R8", '0, 1'b0);

      // Random mix, compared every cycle
      for (int i = 0; i < 4000; i++) begin
         a_in    = ($urandom % 8 == 0) ? '1 : OPW'($urandom);
         b_in    = OPW'($urandom);
         a_shin  = OPW'($urandom);
         b_shin  = OPW'($urandom);
         a_sel   = 1'($urandom);
         b_sel   = 1'($urandom);
         sgn     = 1'($urandom);
         sub     = 1'($urandom);
         acc_ld  = ($urandom % 16 == 0);
         ld_zero = 1'($urandom);
         ce      = ($urandom % 8 != 0);
         rst     = ($urandom % 500 == 0);
         tick("R1");
      end
      rst = 1'b0;

      // R7: long unsigned run of full-scale products overflows the top
      clear();
      drive('1, '1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 65600; i++) tick("R7");
      flush("R7");
      checks++;
      if (ovf !== 1'b1) begin
         fails++;
         $display("FAIL R7: ovf=%b expected 1 after unsigned wrap", ovf);
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule